// File: doc/BRIEF.md
# Sequential Floating-Point Adder/Subtractor (24-bit byte-oriented format)

This block adds or subtracts two numbers held in a compact 24-bit floating-point word. The word's top byte is an exponent biased by 127. The low 16 bits hold the fraction. The fraction's most significant position stores the sign, because the leading one is implied. An exponent byte of zero encodes the value zero. A start strobe samples both operands, the add/subtract select and two option inputs: round-to-nearest enable and saturation enable. The block then runs a short sequence through its steps:

- It swaps the operands if needed, so that the larger exponent comes first.
- It aligns the smaller fraction one bit per cycle.
- It adds the fractions, or subtracts them when the signs differ.
- It normalizes one bit per cycle.
- It rounds and packs the result.

When the result is ready, a one-cycle done pulse marks the cycle in which the result, a flag byte and a status byte all update. These outputs hold their values until the next completion. A host typically chains operations by feeding the result word back as an operand.

Top module: `fpas_addsub`

## Requirements
- R1: Word layout is bits [23:16] biased exponent, bit 15 sign (1 = negative), bits [14:0] fraction below an implied leading one. Same-sign operands add magnitudes. A carry out of the magnitude sum shifts it right one place and raises the exponent by one (0x7F0000 + 0x7F0000 = 0x800000).
- R2: With the select high, the result is A minus B, computed as A plus B with B's sign inverted. When the effective signs differ, the smaller magnitude is subtracted from the larger one, and the result carries the sign of the larger one (0x8DFBA8 + 0x890C00 = 0x8DF2E8; 0x8C0B14 − 0x8F8B14 = 0x8F1C76; 0x7E0000 − 0x7F0000 = 0x7E8000).
- R3: An operand whose exponent byte is 0 is zero. The result is then the other operand, with B's sign inverted when subtracting. Any zero result, including an exact cancellation, is output as 0x000000 with no exception flag set.
- R4: When the exponents differ by 16 or more, the operand with the larger exponent is returned unchanged, apart from the subtraction sign flip. A difference of 15 is still aligned and added (0x8E0000 + 0x7F0000 = 0x8E0001; 0x8F0000 + 0x7F0000 = 0x8F0000).
- R5: After the add, the fraction is shifted left until its top bit is one, and the exponent drops by one per shift (0x7F0000 − 0x7E0000 = 0x7E0000).
- R6: The block keeps one guard bit below the result LSB. With rounding enabled, the result is incremented only when both the guard bit and the LSB are 1. A carry out of this increment renormalizes the result. With rounding disabled, the guard bit is discarded.
- R7: If the exponent would exceed 0xFF, flag bit 1 is set. With saturation enabled, the result becomes exponent 0xFF, fraction all ones and the correct sign. Without saturation, the exponent keeps only its low 8 bits.
- R8: If normalization would take the exponent below 1, flag bit 2 is set and the result is 0x000000.
- R9: Flag byte layout: bit 7 is the saturation option used, bit 6 is the rounding option used, bit 2 is underflow, bit 1 is overflow, and all other bits are 0. The status byte is 0xFF when bit 1 or bit 2 is set, and 0x00 otherwise.
- R10: The done output pulses high for exactly one cycle per operation. Result, flags and status change only in that cycle. A start pulse that arrives while an operation is in progress is ignored.
- R11: During and after reset, before any operation, done, result, flags and status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| sub_i | input | 1 | 1 = A minus B, 0 = A plus B |
| rnd_en_i | input | 1 | Round-to-nearest enable |
| sat_en_i | input | 1 | Saturation enable |
| a_i | input | 24 | Operand A |
| b_i | input | 24 | Operand B |
| result_o | output | 24 | Result word |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | 0xFF on exception, 0x00 otherwise |
| flags_o | output | 8 | Exception flags and option echo |

## Verification
The assertions rely on operands and options being sampled only on the start cycle of an idle block. Past that cycle they assume nothing about the inputs, since the block ignores its inputs while busy. The stimulus holds a_i, b_i and the options steady from the start pulse until done, except in the one test that deliberately changes them mid-operation to show that they are ignored. The assertions also take for granted that every operand with a nonzero exponent is a normalized number. The stimulus uses only such operands or true zeros. It reaches overflow and underflow through exponent extremes (0xFF and 0x01) rather than through any denormal encoding.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_ADD, ST_NORM, ST_ROUND, ST_DONE
  } fpas_state_e;

  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_RND = 6;
  localparam int FLG_SAT = 7;
endpackage

// File: rtl/fpas_unpack.sv
module fpas_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic [EXP_W+MAN_W-1:0] word_i,
  input  logic                   flip_i,
  output logic [EXP_W-1:0]       exp_o,
  output logic                   sign_o,
  output logic [MAN_W-1:0]       mant_o,
  output logic                   zero_o,
  output logic [EXP_W+MAN_W-1:0] word_o
);
  assign exp_o  = word_i[EXP_W+MAN_W-1:MAN_W];
  assign sign_o = word_i[MAN_W-1] ^ flip_i;
  assign mant_o = {1'b1, word_i[MAN_W-2:0]};
  assign zero_o = (exp_o == '0);
  assign word_o = {exp_o, sign_o, word_i[MAN_W-2:0]};
endmodule

// File: rtl/fpas_round.sv
module fpas_round #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic [MAN_W:0]         mant_i,  // normalized, LSB is guard
  input  logic [EXP_W:0]         exp_i,
  input  logic                   sign_i,
  input  logic                   rnd_en_i,
  input  logic                   sat_en_i,
  output logic [EXP_W+MAN_W-1:0] word_o,
  output logic                   ovf_o
);
  logic           up;
  logic [MAN_W:0] m_r;
  logic [EXP_W:0] e_r;
  logic [MAN_W-2:0] frac;

  // single guard bit: a tie always resolves to even
  assign up   = rnd_en_i & mant_i[0] & mant_i[1];
  assign m_r  = {1'b0, mant_i[MAN_W:1]} + {{MAN_W{1'b0}}, up};
  assign e_r  = exp_i + {{EXP_W{1'b0}}, m_r[MAN_W]};
  assign frac = m_r[MAN_W] ? m_r[MAN_W-1:1] : m_r[MAN_W-2:0];
  assign ovf_o = e_r[EXP_W];

  always_comb begin
    if (ovf_o && sat_en_i) word_o = {{EXP_W{1'b1}}, sign_i, {(MAN_W-1){1'b1}}};
    else                   word_o = {e_r[EXP_W-1:0], sign_i, frac};
  end
endmodule

// File: rtl/fpas_addsub.sv
module fpas_addsub
  import fpas_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   sub_i,
  input  logic                   rnd_en_i,
  input  logic                   sat_en_i,
  input  logic [EXP_W+MAN_W-1:0] a_i,
  input  logic [EXP_W+MAN_W-1:0] b_i,
  output logic [EXP_W+MAN_W-1:0] result_o,
  output logic                   done_o,
  output logic [7:0]             status_o,
  output logic [7:0]             flags_o
);
  localparam int W     = EXP_W + MAN_W;
  localparam int EXT_W = MAN_W + 1;
  localparam int CNT_W = $clog2(MAN_W);
  localparam logic [EXP_W-1:0] DIFF_LIM = EXP_W'(MAN_W);
  localparam logic [EXP_W:0]   EXP_ONE  = (EXP_W+1)'(1);

  // operand unpack (index 0 = A, 1 = B)
  logic [W-1:0]     op_w   [2];
  logic             op_f   [2];
  logic [EXP_W-1:0] op_e   [2];
  logic             op_s   [2];
  logic [MAN_W-1:0] op_m   [2];
  logic             op_z   [2];
  logic [W-1:0]     op_eff [2];

  assign op_w[0] = a_i;  assign op_f[0] = 1'b0;
  assign op_w[1] = b_i;  assign op_f[1] = sub_i;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp (
      .word_i(op_w[g]), .flip_i(op_f[g]), .exp_o(op_e[g]), .sign_o(op_s[g]),
      .mant_o(op_m[g]), .zero_o(op_z[g]), .word_o(op_eff[g]));
  end

  logic             swap;
  logic [EXP_W-1:0] ediff;
  assign swap  = op_e[1] > op_e[0];
  assign ediff = swap ? op_e[1] - op_e[0] : op_e[0] - op_e[1];

  fpas_state_e      st_q, st_d;
  logic [EXT_W-1:0] big_q, big_d, sml_q, sml_d, mnt_q, mnt_d;
  logic [EXP_W:0]   exp_q, exp_d;
  logic             sgn_q, sgn_d, dif_q, dif_d, rnd_q, rnd_d, sat_q, sat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     res_q, fin_res, rnd_word;
  logic [7:0]       flg_q, sta_q;
  logic             fin, fin_ovf, fin_unf, rnd_ovf, opt_rnd, opt_sat;

  logic [EXT_W:0]   sml_x, addend, sum;
  logic [EXT_W-1:0] neg;
  assign sml_x  = {1'b0, sml_q};
  assign addend = dif_q ? (~sml_x + 1'b1) : sml_x;
  assign sum    = {1'b0, big_q} + addend;
  assign neg    = ~sum[EXT_W-1:0] + 1'b1;

  fpas_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
    .mant_i(mnt_q), .exp_i(exp_q), .sign_i(sgn_q), .rnd_en_i(rnd_q),
    .sat_en_i(sat_q), .word_o(rnd_word), .ovf_o(rnd_ovf));

  always_comb begin
    st_d = st_q; big_d = big_q; sml_d = sml_q; mnt_d = mnt_q; exp_d = exp_q;
    sgn_d = sgn_q; dif_d = dif_q; cnt_d = cnt_q; rnd_d = rnd_q; sat_d = sat_q;
    fin = 1'b0; fin_res = '0; fin_ovf = 1'b0; fin_unf = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        rnd_d = rnd_en_i;
        sat_d = sat_en_i;
        if (op_z[0]) begin
          fin = 1'b1;
          fin_res = op_z[1] ? '0 : op_eff[1];
        end else if (op_z[1]) begin
          fin = 1'b1;
          fin_res = op_eff[0];
        end else if (ediff >= DIFF_LIM) begin
          fin = 1'b1;
          fin_res = swap ? op_eff[1] : op_eff[0];
        end else begin
          big_d = {(swap ? op_m[1] : op_m[0]), 1'b0};
          sml_d = {(swap ? op_m[0] : op_m[1]), 1'b0};
          exp_d = {1'b0, (swap ? op_e[1] : op_e[0])};
          sgn_d = swap ? op_s[1] : op_s[0];
          dif_d = op_s[0] ^ op_s[1];
          cnt_d = ediff[CNT_W-1:0];
          st_d  = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (cnt_q == '0) st_d = ST_ADD;
        else begin
          sml_d = sml_q >> 1;
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ADD: begin
        st_d = ST_NORM;
        if (!dif_q) begin
          if (sum[EXT_W]) begin
            mnt_d = sum[EXT_W:1];
            exp_d = exp_q + 1'b1;
          end else mnt_d = sum[EXT_W-1:0];
        end else if (sum == '0) begin
          fin = 1'b1;
        end else if (sum[EXT_W]) begin
          mnt_d = neg;
          sgn_d = ~sgn_q;
        end else mnt_d = sum[EXT_W-1:0];
      end
      ST_NORM: begin
        if (mnt_q[EXT_W-1]) st_d = ST_ROUND;
        else if (exp_q <= EXP_ONE) begin
          fin = 1'b1;
          fin_unf = 1'b1;
        end else begin
          mnt_d = mnt_q << 1;
          exp_d = exp_q - 1'b1;
        end
      end
      ST_ROUND: begin
        fin = 1'b1;
        fin_res = rnd_word;
        fin_ovf = rnd_ovf;
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_DONE;
  end

  assign opt_rnd = (st_q == ST_IDLE) ? rnd_en_i : rnd_q;
  assign opt_sat = (st_q == ST_IDLE) ? sat_en_i : sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; big_q <= '0; sml_q <= '0; mnt_q <= '0; exp_q <= '0;
      sgn_q <= 1'b0; dif_q <= 1'b0; cnt_q <= '0; rnd_q <= 1'b0; sat_q <= 1'b0;
      res_q <= '0; flg_q <= '0; sta_q <= '0;
    end else begin
      st_q <= st_d; big_q <= big_d; sml_q <= sml_d; mnt_q <= mnt_d; exp_q <= exp_d;
      sgn_q <= sgn_d; dif_q <= dif_d; cnt_q <= cnt_d; rnd_q <= rnd_d; sat_q <= sat_d;
      if (fin) begin
        res_q <= fin_res;
        flg_q <= '0;
        flg_q[FLG_OVF] <= fin_ovf;
        flg_q[FLG_UNF] <= fin_unf;
        flg_q[FLG_RND] <= opt_rnd;
        flg_q[FLG_SAT] <= opt_sat;
        sta_q <= (fin_ovf | fin_unf) ? 8'hFF : 8'h00;
      end
    end
  end

  assign result_o = res_q;
  assign done_o   = (st_q == ST_DONE);
  assign status_o = sta_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/fpas_addsub_chk.sv
module fpas_addsub_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   done_o,
  input logic [EXP_W+MAN_W-1:0] result_o,
  input logic [7:0]             status_o,
  input logic [7:0]             flags_o
);
  localparam int W = EXP_W + MAN_W;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(flags_o) && $stable(status_o)); // R10

  AST_STATUS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 8'hFF) == (flags_o[2:1] != 2'b00) && (status_o == 8'hFF || status_o == 8'h00)); // R9

  AST_FLAG_SPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flags_o[5:3] == 3'b000 && !flags_o[0] && !(flags_o[1] && flags_o[2])); // R9

  AST_ZERO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !flags_o[1] && result_o[W-1:MAN_W] == '0 |-> result_o[MAN_W-1:0] == '0); // R3

  AST_SAT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && flags_o[1] && flags_o[7]
      |-> result_o[W-1:MAN_W] == '1 && result_o[MAN_W-2:0] == '1); // R7

  AST_UNF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && flags_o[2] |-> result_o == '0); // R8
endmodule

bind fpas_addsub fpas_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o),
  .result_o(result_o), .status_o(status_o), .flags_o(flags_o));

// File: tb/fpas_addsub_test.sv
module fpas_addsub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sub = 1'b0, rnd = 1'b0, sat = 1'b0;
  logic [23:0] a = '0, b = '0;
  logic [23:0] result;
  logic        done;
  logic [7:0]  status, flags;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  fpas_addsub uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub),
    .rnd_en_i(rnd), .sat_en_i(sat), .a_i(a), .b_i(b),
    .result_o(result), .done_o(done), .status_o(status), .flags_o(flags));

  typedef struct packed {
    logic [7:0]  req;
    logic [23:0] a, b;
    logic        sub, rnd, sat;
    logic [23:0] res;
    logic [7:0]  flg;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 24'h8DFBA8, 24'h890C00, 1'b0, 1'b1, 1'b0, 24'h8DF2E8, 8'h40}, // R2
    '{8'd2, 24'h8C0B14, 24'h8F8B14, 1'b1, 1'b1, 1'b0, 24'h8F1C76, 8'h40}, // R2
    '{8'd1, 24'h7F0000, 24'h7F0000, 1'b0, 1'b0, 1'b0, 24'h800000, 8'h00}, // R1
    '{8'd3, 24'h7F0000, 24'h7F0000, 1'b1, 1'b0, 1'b0, 24'h000000, 8'h00}, // R3
    '{8'd5, 24'h7F0000, 24'h7E0000, 1'b1, 1'b0, 1'b0, 24'h7E0000, 8'h00}, // R5
    '{8'd2, 24'h7E0000, 24'h7F0000, 1'b1, 1'b0, 1'b0, 24'h7E8000, 8'h00},
    '{8'd3, 24'h000000, 24'h8C0B14, 1'b0, 1'b0, 1'b0, 24'h8C0B14, 8'h00},
    '{8'd3, 24'h000000, 24'h8C0B14, 1'b1, 1'b0, 1'b0, 24'h8C8B14, 8'h00},
    '{8'd3, 24'h8F8B14, 24'h000000, 1'b1, 1'b0, 1'b0, 24'h8F8B14, 8'h00},
    '{8'd4, 24'h900000, 24'h7F0000, 1'b0, 1'b0, 1'b0, 24'h900000, 8'h00}, // R4
    '{8'd4, 24'h7F0000, 24'h900000, 1'b1, 1'b0, 1'b0, 24'h908000, 8'h00},
    '{8'd4, 24'h8E0000, 24'h7F0000, 1'b0, 1'b0, 1'b0, 24'h8E0001, 8'h00},
    '{8'd4, 24'h8F0000, 24'h7F0000, 1'b0, 1'b0, 1'b0, 24'h8F0000, 8'h00},
    '{8'd6, 24'h7F0001, 24'h7E0001, 1'b0, 1'b1, 1'b0, 24'h7F4002, 8'h40}, // R6
    '{8'd6, 24'h7F0001, 24'h7E0001, 1'b0, 1'b0, 1'b0, 24'h7F4001, 8'h00},
    '{8'd6, 24'h7F0000, 24'h7E0001, 1'b0, 1'b1, 1'b0, 24'h7F4000, 8'h40},
    '{8'd6, 24'h7F7FFE, 24'h704000, 1'b0, 1'b1, 1'b0, 24'h800000, 8'h40},
    '{8'd6, 24'h7F7FFE, 24'h704000, 1'b0, 1'b0, 1'b0, 24'h7F7FFF, 8'h00},
    '{8'd7, 24'hFF0000, 24'hFF0000, 1'b0, 1'b0, 1'b0, 24'h000000, 8'h02}, // R7
    '{8'd7, 24'hFF0000, 24'hFF0000, 1'b0, 1'b0, 1'b1, 24'hFF7FFF, 8'h82},
    '{8'd7, 24'hFF8000, 24'hFF8000, 1'b0, 1'b1, 1'b1, 24'hFFFFFF, 8'hC2},
    '{8'd8, 24'h010001, 24'h010000, 1'b1, 1'b0, 1'b0, 24'h000000, 8'h04}, // R8
    '{8'd8, 24'h010001, 24'h010000, 1'b1, 1'b0, 1'b1, 24'h000000, 8'h84}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 64; n++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [23:0] va, input logic [23:0] vb,
                     input logic vs, input logic vr, input logic vt);
    a = va; b = vb; sub = vs; rnd = vr; sat = vt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 result", 32'(result), 32'h0);
    check("R11 done", 32'(done), 32'h0);
    check("R11 flags", 32'(flags), 32'h0);
    check("R11 status", 32'(status), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle done", 32'(done), 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      run(VEC[i].a, VEC[i].b, VEC[i].sub, VEC[i].rnd, VEC[i].sat);
      wait_done(seen);
      check({tag, " done"}, 32'(seen), 32'h1);
      check({tag, " result"}, 32'(result), 32'(VEC[i].res));
      check({tag, " flags R9"}, 32'(flags), 32'(VEC[i].flg));
      check({tag, " status R9"}, 32'(status),
            (VEC[i].flg[2:1] != 2'b00) ? 32'hFF : 32'h00);
      @(negedge clk);
      check({tag, " pulse R10"}, 32'(done), 32'h0);
      check({tag, " hold R10"}, 32'(result), 32'(VEC[i].res));
    end

    // R10: start pulse during an operation is ignored
    run(24'h7F0000, 24'h7F0000, 1'b0, 1'b0, 1'b0);
    a = 24'h8C0B14; b = 24'h000000; sub = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    check("R10 busy start ignored", 32'(result), 32'h800000);
    check("R10 busy flags", 32'(flags), 32'h00);
    repeat (4) @(negedge clk);
    check("R10 no second done", 32'(done), 32'h0);
    check("R10 result held", 32'(result), 32'h800000);

    // R3: both operands zero
    run(24'h000000, 24'h000000, 1'b1, 1'b0, 1'b0);
    wait_done(seen);
    check("R3 zero minus zero", 32'(result), 32'h0);

    // R11: reset mid-stream clears outputs
    run(24'hFF0000, 24'hFF0000, 1'b0, 1'b0, 1'b1);
    wait_done(seen);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 re-reset result", 32'(result), 32'h0);
    check("R11 re-reset flags", 32'(flags), 32'h0);
    check("R11 re-reset status", 32'(status), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule